// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register window a host processor uses to hand a command to an embedded controller and to collect the outcome. The host sees a 256-byte window on a simple register bus: a write-only command word, a read-only status word, a four-word outgoing data buffer and a four-word response buffer. Writing the command word is the doorbell. It marks the mailbox busy and sends a one-cycle notification, with the command word and the outgoing buffer, to the controller side.

The controller answers with a done strobe that carries an error flag, an error code and the response data. The mailbox then clears busy, records the outcome in the status word and loads the response buffer. If the accepted command asked for it, the mailbox also raises a single-cycle completion interrupt to the host. The host can poll the status word for busy instead.

The sequencer has four states. `ST_IDLE` waits for a command write and moves to `ST_NOTIFY`. `ST_NOTIFY` drives the notification for one cycle, then moves to `ST_DONE` if the done strobe is already present, or to `ST_WAIT` if not. `ST_WAIT` holds until the done strobe arrives, then moves to `ST_DONE`. `ST_DONE` raises the interrupt when requested. From `ST_DONE`, a new command write leads straight back to `ST_NOTIFY`; otherwise the sequencer returns to `ST_IDLE`.

Top module: `hostctl_mailbox`

## Requirements
- R1: After reset, busy and error are 0, the status word at offset 0x04 reads 0x0000_0100 (only the initiator field, default 0x01, is non-zero), the response buffer reads 0, and neither `c_cmd_valid` nor `host_irq` is asserted.
- R2: A write to offset 0x00 while not busy is accepted. In the following cycle, `c_cmd_valid` is high for exactly one cycle, `c_cmd_word` carries the written word, status bit 0 (busy) reads 1 and status bit 1 (error) reads 0.
- R3: A write to offset 0x00 while busy is ignored. It produces no second notification and leaves `c_cmd_word` unchanged.
- R4: A done strobe while busy clears busy in the next cycle. It also latches the error flag into status bit 1, the error code into status bits 23:16, and bits 15:12 of the accepted command into status bits 7:4.
- R5: In the cycle after an accepted done strobe, `host_irq` pulses for exactly one cycle if bit 8 of the accepted command was 1. It stays low if that bit was 0.
- R6: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C store 32-bit words 0 to 3 of the outgoing buffer, and word i is driven on `c_wbuf[32*i+31:32*i]`.
- R7: The response buffer changes only on an accepted done strobe, which loads it from `c_rbuf`. Byte k of the buffer is `c_rbuf[8k+7:8k]`. A read at offset 0x90+a returns the containing word shifted right by 8 times a[1:0], so the addressed byte is in bits 7:0.
- R8: Reads of offset 0x00, of the outgoing buffer and of unmapped offsets return 0. Writes to the status word or to the response buffer change nothing that the host can read.
- R9: A done strobe while not busy is ignored. Status, response buffer and `host_irq` are unaffected.
- R10: A command write in the same cycle as an accepted done strobe is ignored. The done strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 8 | Host byte offset in the window |
| h_wr | input | 1 | Host write enable |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` (combinational) |
| c_cmd_valid | output | 1 | One-cycle notification to the controller |
| c_cmd_word | output | 32 | Accepted command word |
| c_wbuf | output | 128 | Outgoing data buffer, word 0 in the low bits |
| c_done | input | 1 | Controller completion strobe |
| c_err | input | 1 | Error flag qualified by `c_done` |
| c_err_code | input | 8 | Error code qualified by `c_done` |
| c_rbuf | input | 128 | Response data qualified by `c_done` |
| host_irq | output | 1 | Single-cycle completion interrupt |

## Verification
Two events can land in the same clock edge: the controller's done strobe, and a host write of a new command. The bench provokes this by raising `c_done` and a command write together while a command with the interrupt bit set is outstanding. A correct design lets the done strobe win. The scoreboard then sees no second notification, the command word stays that of the first command, the status carries the new error code and command id with busy clear, and exactly one interrupt arrives.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NOTIFY = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } mbx_state_e;

    // Byte offsets inside the host window
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_WBUF = 8'h80;
    localparam logic [7:0] OFS_RBUF = 8'h90;

    // Command word field positions
    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_SUB_LSB = 12;
    localparam int CMD_SUB_W   = 4;

endpackage

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_ioc,
    input  logic done,
    output logic notify,
    output logic busy,
    output logic irq,
    output logic accept,
    output logic done_take
);

    mbx_state_e state_q, state_d;
    logic       ioc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ioc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ioc_q <= cmd_ioc;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr) state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = done ? ST_DONE : ST_WAIT;
            ST_WAIT:   if (done) state_d = ST_DONE;
            ST_DONE:   state_d = cmd_wr ? ST_NOTIFY : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        notify = 1'b0;
        busy   = 1'b0;
        irq    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_NOTIFY: begin notify = 1'b1; busy = 1'b1; end
            ST_WAIT:   busy = 1'b1;
            ST_DONE:   irq = ioc_q;
            default:   ;
        endcase
        accept    = cmd_wr && !busy;
        done_take = done && busy;
    end

endmodule

// File: rtl/mbx_wbuf.sv
module mbx_wbuf #(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BITS  = WORDS * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    output logic [BITS-1:0]  flat
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                word_q <= wr_data;
            end
        end
        assign flat[32*g +: 32] = word_q;
    end

endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf #(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BITS  = WORDS * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BITS-1:0]  load_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [BITS-1:0]  flat
);

    logic [31:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (load) begin
                words[g] <= load_data[32*g +: 32];
            end
        end
        assign flat[32*g +: 32] = words[g];
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_word = words[i];
            end
        end
    end

endmodule

// File: rtl/hostctl_mailbox.sv
module hostctl_mailbox
    import mbx_pkg::*;
#(
    parameter int          BUF_WORDS    = 4,
    parameter logic [7:0]  INITIATOR_ID = 8'h01,
    localparam int         BUF_BITS     = BUF_WORDS * 32,
    localparam int         BUF_BYTES    = BUF_WORDS * 4,
    localparam int         IDX_W        = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          h_addr,
    input  logic                h_wr,
    input  logic [31:0]         h_wdata,
    output logic [31:0]         h_rdata,
    output logic                c_cmd_valid,
    output logic [31:0]         c_cmd_word,
    output logic [BUF_BITS-1:0] c_wbuf,
    input  logic                c_done,
    input  logic                c_err,
    input  logic [7:0]          c_err_code,
    input  logic [BUF_BITS-1:0] c_rbuf,
    output logic                host_irq
);

    // Address decode
    logic in_wbuf, in_rbuf, is_cmd, is_stat;
    logic [IDX_W-1:0] word_idx;

    always_comb begin
        is_cmd   = (h_addr[7:2] == OFS_CMD[7:2]);
        is_stat  = (h_addr[7:2] == OFS_STAT[7:2]);
        in_wbuf  = (h_addr >= OFS_WBUF) && (h_addr < OFS_WBUF + 8'(BUF_BYTES));
        in_rbuf  = (h_addr >= OFS_RBUF) && (h_addr < OFS_RBUF + 8'(BUF_BYTES));
        word_idx = IDX_W'(h_addr[7:2]);
    end

    // Sequencer
    logic busy, accept, done_take;

    mbx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (h_wr && is_cmd),
        .cmd_ioc   (h_wdata[CMD_IOC_BIT]),
        .done      (c_done),
        .notify    (c_cmd_valid),
        .busy      (busy),
        .irq       (host_irq),
        .accept    (accept),
        .done_take (done_take)
    );

    // Command and status registers
    logic [31:0]          cmd_q;
    logic                 err_q;
    logic [7:0]           code_q;
    logic [CMD_SUB_W-1:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            err_q  <= 1'b0;
            code_q <= '0;
            id_q   <= '0;
        end else if (accept) begin
            cmd_q <= h_wdata;
            err_q <= 1'b0;
        end else if (done_take) begin
            err_q  <= c_err;
            code_q <= c_err_code;
            id_q   <= cmd_q[CMD_SUB_LSB +: CMD_SUB_W];
        end
    end

    assign c_cmd_word = cmd_q;

    logic [31:0] status_word;
    assign status_word = {8'h00, code_q, INITIATOR_ID, id_q, 2'b00, err_q, busy};

    // Data buffers
    mbx_wbuf #(.WORDS(BUF_WORDS)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (h_wr && in_wbuf),
        .wr_idx  (word_idx),
        .wr_data (h_wdata),
        .flat    (c_wbuf)
    );

    logic [31:0]         rsp_word;
    logic [BUF_BITS-1:0] rsp_flat;

    mbx_rbuf #(.WORDS(BUF_WORDS)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done_take),
        .load_data (c_rbuf),
        .rd_idx    (word_idx),
        .rd_word   (rsp_word),
        .flat      (rsp_flat)
    );

    // Read path: word select, then byte-lane alignment
    logic [31:0] sel_word;

    always_comb begin
        sel_word = '0;
        if (is_stat) begin
            sel_word = status_word;
        end else if (in_rbuf) begin
            sel_word = rsp_word;
        end
        h_rdata = sel_word >> {h_addr[1:0], 3'b000};
    end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int RSP_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                accept,
    input logic                c_cmd_valid,
    input logic [31:0]         c_cmd_word,
    input logic                c_done,
    input logic                host_irq,
    input logic [31:0]         status_word,
    input logic [RSP_BITS-1:0] rsp_flat
);

    p_notify_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_cmd_valid |=> !c_cmd_valid);

    p_notify_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_cmd_valid |-> busy);

    p_word_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(c_cmd_word));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_done && busy) |=> !busy);

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq);

    p_irq_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(busy));

    p_rsp_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_done && busy) |=> $stable(rsp_flat));

    p_idle_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_done && !busy && !accept) |=> $stable(status_word));

endmodule

bind hostctl_mailbox mbx_checker #(.RSP_BITS(BUF_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .accept      (accept),
    .c_cmd_valid (c_cmd_valid),
    .c_cmd_word  (c_cmd_word),
    .c_done      (c_done),
    .host_irq    (host_irq),
    .status_word (status_word),
    .rsp_flat    (rsp_flat)
);

// File: tb/test_hostctl_mailbox.sv
module test_hostctl_mailbox;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   h_addr = '0;
    logic         h_wr = 1'b0;
    logic [31:0]  h_wdata = '0;
    logic [31:0]  h_rdata;
    logic         c_cmd_valid;
    logic [31:0]  c_cmd_word;
    logic [127:0] c_wbuf;
    logic         c_done = 1'b0;
    logic         c_err = 1'b0;
    logic [7:0]   c_err_code = '0;
    logic [127:0] c_rbuf = '0;
    logic         host_irq;

    always #10 clk = ~clk;

    hostctl_mailbox i_hostctl_mailbox (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .c_cmd_valid(c_cmd_valid), .c_cmd_word(c_cmd_word),
        .c_wbuf(c_wbuf), .c_done(c_done), .c_err(c_err), .c_err_code(c_err_code),
        .c_rbuf(c_rbuf), .host_irq(host_irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Scoreboard: expected notifications and interrupts
    logic [31:0] exp_cmd[$];
    int          exp_irq = 0;

    always @(negedge clk) begin
        if (rst_n && c_cmd_valid) begin
            if (exp_cmd.size() == 0) begin
                check("R3 unexpected notification", c_cmd_word, 32'hFFFF_FFFF);
            end else begin
                check("R2 notified command word", c_cmd_word, exp_cmd.pop_front());
            end
        end
        if (rst_n && host_irq) begin
            check("R5 interrupt expected", 32'(exp_irq > 0), 32'd1);
            if (exp_irq > 0) exp_irq--;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic done_pulse(input logic e, input logic [7:0] code);
        @(negedge clk);
        c_done = 1'b1; c_err = e; c_err_code = code;
        @(negedge clk);
        c_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, d); check("R1 status after reset", d, 32'h0000_0100);
        rd(8'h90, d); check("R1 response after reset", d, 32'h0);
        check("R1 irq low", 32'(host_irq), 32'd0);
        check("R1 notify low", 32'(c_cmd_valid), 32'd0);

        // R6 outgoing buffer
        wr(8'h80, 32'hA000_0001);
        wr(8'h84, 32'hB000_0002);
        wr(8'h88, 32'hC000_0003);
        wr(8'h8C, 32'hD000_0004);
        check("R6 word0", c_wbuf[31:0],   32'hA000_0001);
        check("R6 word1", c_wbuf[63:32],  32'hB000_0002);
        check("R6 word3", c_wbuf[127:96], 32'hD000_0004);

        // R2 accepted command with interrupt request, R3 ignored second write
        exp_cmd.push_back(32'h0010_A1FF);
        wr(8'h00, 32'h0010_A1FF);
        check("R2 notify pulse", 32'(c_cmd_valid), 32'd1);
        rd(8'h04, d); check("R2 busy set", d, 32'h0000_0101);
        wr(8'h00, 32'h0000_20F4);
        check("R3 command word held", c_cmd_word, 32'h0010_A1FF);

        // R4 R5 R7 completion with error
        c_rbuf = {32'hDDEE_FF00, 32'h99AA_BBCC, 32'h5566_7788, 32'h1122_3344};
        exp_irq++;
        done_pulse(1'b1, 8'h5A);
        rd(8'h04, d); check("R4 status after done", d, 32'h005A_01A2);
        rd(8'h94, d); check("R7 word read", d, 32'h5566_7788);
        rd(8'h97, d); check("R7 byte read", d, 32'h0000_0055);
        rd(8'h9A, d); check("R7 half lane read", d, 32'h0000_99AA);

        // R2 error clear, R5 no interrupt, R7 load only on done
        exp_cmd.push_back(32'h0000_30F8);
        wr(8'h00, 32'h0000_30F8);
        rd(8'h04, d); check("R2 error cleared on accept", d, 32'h005A_01A1);
        c_rbuf = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        rd(8'h90, d); check("R7 held while busy", d, 32'h1122_3344);
        done_pulse(1'b0, 8'h00);
        rd(8'h04, d); check("R4 status second done", d, 32'h0000_0130);
        rd(8'h90, d); check("R7 loaded on done", d, 32'h0302_0100);
        rd(8'h9D, d); check("R7 byte lane 1", d, 32'h000F_0E0D);

        // R9 done while idle
        c_rbuf = '1;
        done_pulse(1'b1, 8'h77);
        rd(8'h04, d); check("R9 status unchanged", d, 32'h0000_0130);
        rd(8'h90, d); check("R9 response unchanged", d, 32'h0302_0100);

        // R8 read-only writes and zero reads
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h90, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R8 status write ignored", d, 32'h0000_0130);
        rd(8'h90, d); check("R8 response write ignored", d, 32'h0302_0100);
        rd(8'h00, d); check("R8 command reads zero", d, 32'h0);
        rd(8'h84, d); check("R8 write buffer reads zero", d, 32'h0);
        rd(8'h40, d); check("R8 unmapped reads zero", d, 32'h0);

        // R10 done and command write in the same cycle
        exp_cmd.push_back(32'h0000_51F0);
        wr(8'h00, 32'h0000_51F0);
        exp_irq++;
        @(negedge clk);
        c_done = 1'b1; c_err = 1'b0; c_err_code = 8'h33;
        h_addr = 8'h00; h_wdata = 32'h0000_6204; h_wr = 1'b1;
        @(negedge clk);
        c_done = 1'b0; h_wr = 1'b0;
        check("R10 command word kept", c_cmd_word, 32'h0000_51F0);
        rd(8'h04, d); check("R10 done took effect", d, 32'h0033_0150);

        repeat (4) @(negedge clk);
        check("R2 all notifications seen", 32'(exp_cmd.size()), 32'd0);
        check("R5 all interrupts seen", 32'(exp_irq), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule